// File: doc/BRIEF.md
# 8 kHz Frame Strobe Generator with Selectable Shape

This block divides a fast, synchronous output clock down to an 8 kHz frame reference. A phase counter walks through `DIV` clock cycles per frame, where `DIV` is the clock rate divided by 8000 (2430 for a 19.44 MHz clock). A decoder turns the counter value into the frame output. The output is either a square wave with a 50% duty cycle, or a high-going pulse at the start of each frame. The pulse width is a 4-bit count of clock cycles.

In master mode the counter runs freely and the reference input has no effect. In slave mode the block waits for a rising edge on the asynchronous 8 kHz reference input. The input first passes through a two-stage synchronizer. Each detected edge reloads the counter, so that the next frame start falls a programmed, signed number of clock cycles after the edge. A negative offset wraps within the frame period, so the frame starts that many cycles before the following reference edge. Between entering slave mode and the first reference edge, the output stays low.

The control state machine has four states:
- `FP_IDLE`: held by reset. The output is low and the counter is parked.
- `FP_MASTER`: free-running.
- `FP_HUNT`: slave mode, waiting for the first reference edge. The output is forced low.
- `FP_LOCK`: slave mode, aligned. Every further reference edge realigns the counter.

The transitions are:
- `FP_IDLE` moves to `FP_MASTER` or `FP_HUNT` on the first clock edge after reset, according to `slave_i`.
- `FP_MASTER` moves to `FP_HUNT` when `slave_i` rises.
- `FP_HUNT` moves to `FP_LOCK` on a detected reference edge.
- `FP_HUNT` and `FP_LOCK` both return to `FP_MASTER` when `slave_i` falls.

Top module: `frame_pulse_gen`

## Requirements
- R1: The phase counter counts 0 to DIV-1 and then wraps to 0. The output therefore repeats every DIV clock cycles, and a frame starts where the phase is 0.
- R2: When `pulse_mode_i`=0, `frame_o` is high for phases 0 to DIV/2-1 (integer division) and low for the remaining phases.
- R3: When `pulse_mode_i`=1, `frame_o` is high for phases 0 to W-1 and low for the remaining phases. W is the unsigned value of `width_i`, from 1 to 15.
- R4: A `width_i` value of 0 in pulse mode acts as a width of 1.
- R5: In slave mode, let the reference input first be sampled high at clock edge k. The frame then starts (phase 0) at clock edge k+2+m, where m = `offset_i` mod DIV. `offset_i` is a two's complement count of clock cycles. While aligned, each later reference edge realigns the frame in the same way.
- R6: A negative `offset_i` wraps: the frame starts at edge k+2+DIV+`offset_i`. This is |`offset_i`| cycles before the same point in the following period.
- R7: After entering slave mode, `frame_o` stays low until the frame realigned by the first detected reference edge begins.
- R8: In master mode, reference edges have no effect. The output keeps its free-running phase, and it also keeps that phase across a change from slave mode back to master mode.
- R9: `frame_o` is low while reset is asserted and on the first cycle after reset. In master mode, the first frame starts at the second clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast output clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_i | input | 1 | 1 = slave mode (track reference), 0 = master mode |
| ref_i | input | 1 | Asynchronous 8 kHz reference input; its rising edge is used |
| pulse_mode_i | input | 1 | 0 = 50% square wave, 1 = pulse of programmable width |
| width_i | input | WID_W (4) | Pulse width in clock cycles, 0 treated as 1 |
| offset_i | input | OFS_W (8) | Signed slave-mode offset in clock cycles |
| frame_o | output | 1 | 8 kHz frame output |

## Verification
The bench sweeps every signed offset on a small frame (DIV=20). Each offset is tried under both output shapes, and the whole resulting waveform is compared, cycle by cycle, with a phase model kept in the bench. The sweep catches three kinds of error:
- Off-by-one edge latency through the synchronizer.
- Positive offsets applied in the wrong direction.
- Negative offsets that fail to wrap; these would start the frame at a large wrong phase.

All sixteen width codes are swept as well. This catches a width-0 code that produces no pulse at all, and a width compare that is off by one. Further cases check that reference edges in master mode leave the phase untouched, and that a second edge in the aligned state realigns the frame. They also check that the output stays quiet while hunting; a design without that hold would emit a misaligned frame.

// File: rtl/fp_pkg.sv
package fp_pkg;

    typedef enum logic [1:0] {
        FP_IDLE   = 2'd0,
        FP_MASTER = 2'd1,
        FP_HUNT   = 2'd2,
        FP_LOCK   = 2'd3
    } fp_state_e;

endpackage

// File: rtl/fp_ref_sync.sv
module fp_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= ref_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;

    // R5: a detected edge is a single-cycle event
    assert_rise_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/fp_phase_ctr.sv
module fp_phase_ctr #(
    parameter int DIV   = 2430,
    parameter int OFS_W = 8,
    localparam int CW   = $clog2(DIV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [OFS_W-1:0] offset_i,
    output logic [CW-1:0]    cnt_o
);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] load_val;
    logic [CW-1:0] cnt_q;

    // Reload value: the frame starts (count 0) offset mod DIV cycles later
    always_comb begin
        int sv;
        int tmp;
        sv = int'($signed(offset_i));
        if (sv < 0)       tmp = -sv;
        else if (sv == 0) tmp = 0;
        else              tmp = DIV - sv;
        load_val = tmp[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= LAST;
        else if (load_i)  cnt_q <= load_val;
        else if (run_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R1: count stays inside the frame
    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R1: the last phase wraps to zero
    assert_cnt_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && cnt_q == LAST) |=> cnt_q == '0);
    // R5: an alignment load lands the reload value computed from the offset
    assert_load_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == $past(load_val));

endmodule

// File: rtl/fp_shape.sv
module fp_shape #(
    parameter int DIV   = 2430,
    parameter int WID_W = 4,
    localparam int CW   = $clog2(DIV)
) (
    input  logic [CW-1:0]    cnt_i,
    input  logic             enable_i,
    input  logic             pulse_mode_i,
    input  logic [WID_W-1:0] width_i,
    output logic             frame_o
);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] wl;
    logic          sq_hi;
    logic          pl_hi;

    always_comb begin
        wl    = (width_i == '0) ? CW'(1) : CW'(width_i);
        sq_hi = cnt_i < HALF;
        pl_hi = cnt_i < wl;
        frame_o = enable_i & (pulse_mode_i ? pl_hi : sq_hi);
    end

endmodule

// File: rtl/frame_pulse_gen.sv
module frame_pulse_gen
    import fp_pkg::*;
#(
    parameter int DIV         = 2430,
    parameter int WID_W       = 4,
    parameter int OFS_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slave_i,
    input  logic             ref_i,
    input  logic             pulse_mode_i,
    input  logic [WID_W-1:0] width_i,
    input  logic [OFS_W-1:0] offset_i,
    output logic             frame_o
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    fp_state_e     state_q;
    fp_state_e     state_d;
    logic          ref_rise;
    logic          run;
    logic          load;
    logic          shape_en;
    logic [CW-1:0] cnt;

    fp_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (ref_i),
        .rise_o (ref_rise)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FP_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FP_IDLE:   state_d = slave_i ? FP_HUNT : FP_MASTER;
            FP_MASTER: state_d = slave_i ? FP_HUNT : FP_MASTER;
            FP_HUNT:   state_d = !slave_i ? FP_MASTER : (ref_rise ? FP_LOCK : FP_HUNT);
            FP_LOCK:   state_d = slave_i ? FP_LOCK : FP_MASTER;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        run      = 1'b0;
        load     = 1'b0;
        shape_en = 1'b0;
        unique case (state_q)
            FP_IDLE:   ;
            FP_MASTER: begin run = 1'b1; shape_en = 1'b1; end
            FP_HUNT:   begin run = 1'b1; load = slave_i & ref_rise; end
            FP_LOCK:   begin run = 1'b1; load = slave_i & ref_rise; shape_en = 1'b1; end
        endcase
    end

    fp_phase_ctr #(.DIV(DIV), .OFS_W(OFS_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .load_i   (load),
        .offset_i (offset_i),
        .cnt_o    (cnt)
    );

    fp_shape #(.DIV(DIV), .WID_W(WID_W)) u_shape (
        .cnt_i        (cnt),
        .enable_i     (shape_en),
        .pulse_mode_i (pulse_mode_i),
        .width_i      (width_i),
        .frame_o      (frame_o)
    );

    // R7: quiet while hunting for the first reference edge
    assert_hunt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FP_HUNT) |-> !frame_o);
    // R8: in master mode the phase only advances, whatever the reference does
    assert_master_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FP_MASTER && !slave_i) |=>
            cnt == (($past(cnt) == LAST) ? '0 : $past(cnt) + 1'b1));
    // R2: square wave is low in the second half of the frame
    assert_square_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode_i && cnt >= HALF) |-> !frame_o);
    // R3: pulse is low once the programmed width has elapsed
    assert_pulse_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode_i && width_i != '0 && cnt >= CW'(width_i)) |-> !frame_o);
    // R4: zero width still yields a one-cycle pulse at the frame start
    assert_zero_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode_i && width_i == '0 && state_q == FP_MASTER && cnt == '0) |-> frame_o);
    // R9: the cycle leaving reset produces no frame
    assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FP_IDLE) |-> !frame_o);

endmodule

// File: tb/frame_pulse_gen_tb.sv
module frame_pulse_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV   = 20;
    localparam int WID_W = 4;
    localparam int OFS_W = 5;
    localparam int HALF  = DIV / 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             slave_i = 1'b0;
    logic             ref_i = 1'b0;
    logic             pulse_mode_i = 1'b0;
    logic [WID_W-1:0] width_i = '0;
    logic [OFS_W-1:0] offset_i = '0;
    logic             frame_o;

    int  ph = 0;
    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_pulse_gen #(.DIV(DIV), .WID_W(WID_W), .OFS_W(OFS_W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .slave_i(slave_i), .ref_i(ref_i),
        .pulse_mode_i(pulse_mode_i), .width_i(width_i), .offset_i(offset_i),
        .frame_o(frame_o)
    );

    function automatic logic exp_out(int p);
        int wl;
        wl = (width_i == '0) ? 1 : int'(width_i);
        return pulse_mode_i ? (p < wl) : (p < HALF);
    endfunction

    task automatic chk(logic act, logic exp, string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: frame_o=%0b expected %0b (phase %0d, t=%0t)", tag, act, exp, ph, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        ph = (ph + 1) % DIV;
    endtask

    task automatic run_frames(int n, string tag);
        for (int i = 0; i < n * DIV; i++) begin
            tick();
            chk(frame_o, exp_out(ph), tag);
        end
    endtask

    // Enter slave mode, check the quiet hunt, align on one edge, then follow
    task automatic slave_case(int o, logic pm, logic [WID_W-1:0] w, string tag);
        int m;
        slave_i = 1'b0;
        tick();
        slave_i = 1'b1;
        offset_i = OFS_W'(o);
        pulse_mode_i = pm;
        width_i = w;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(frame_o, 1'b0, "R7 hunt");
        end
        ref_i = 1'b1;
        tick();
        chk(frame_o, 1'b0, "R7 hunt edge k");
        tick();
        chk(frame_o, 1'b0, "R7 hunt edge k+1");
        tick();
        m = ((o % DIV) + DIV) % DIV;
        ph = (DIV - m) % DIV;
        chk(frame_o, exp_out(ph), tag);
        ref_i = 1'b0;
        run_frames(2, tag);
    endtask

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(frame_o, 1'b0, "R9 in reset");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(frame_o, 1'b0, "R9 first cycle");
        ph = DIV - 1;

        // R1, R2: master square wave
        run_frames(2, "R1/R2 master square");

        // R3, R4: sweep every width code in pulse mode
        pulse_mode_i = 1'b1;
        for (int w = 0; w < 16; w++) begin
            width_i = WID_W'(w);
            run_frames(1, (w == 0) ? "R4 width zero" : "R3 pulse width");
        end

        // R8: reference edges ignored in master mode
        width_i = 4'd5;
        for (int r = 0; r < 3; r++) begin
            ref_i = 1'b1;
            run_frames(0, "R8");
            for (int i = 0; i < 4; i++) begin
                tick();
                chk(frame_o, exp_out(ph), "R8 ref ignored");
            end
            ref_i = 1'b0;
            for (int i = 0; i < 9; i++) begin
                tick();
                chk(frame_o, exp_out(ph), "R8 ref ignored");
            end
        end

        // R5, R6: sweep every signed offset in both shapes
        for (int o = -(1 << (OFS_W-1)); o < (1 << (OFS_W-1)); o++) begin
            slave_case(o, o[0], WID_W'((o + 16) % 16),
                       (o < 0) ? "R6 negative offset" : "R5 slave offset");
        end

        // R5: realignment while already locked
        offset_i = OFS_W'(0);
        for (int i = 0; i < 7; i++) begin
            tick();
            chk(frame_o, exp_out(ph), "R5 locked");
        end
        ref_i = 1'b1;
        tick();
        chk(frame_o, exp_out(ph), "R5 before realign");
        tick();
        chk(frame_o, exp_out(ph), "R5 before realign");
        tick();
        ph = 0;
        chk(frame_o, exp_out(ph), "R5 realign");
        ref_i = 1'b0;
        run_frames(1, "R5 realigned");

        // R8: back to master keeps phase
        slave_i = 1'b0;
        run_frames(2, "R8 slave to master");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule